// File: doc/BRIEF.md
# Two-Stage Fractional Baud Clock Generator

This block produces the clock enables that pace a serial port's transmitter and receiver. A reference enable, which pulses at twice the base frequency, drives a prescaler. The prescaler's factor is set by a 5-bit select code and runs from 1 to 16 in half steps. Code 0 stops the whole chain. The prescaler ticks feed an 11-bit down-counter that is reloaded with N-1. Its wrap is the sample-rate tick. In asynchronous mode this tick runs at 16 times the bit rate. A final divide then yields a square clock at the bit rate: by 16 in asynchronous mode and by 2 in synchronous mode. That square clock is also output so that it can drive an external clock pin.

Software programs the block through two byte-wide write strobes. The prescaler write carries the select code in its upper five bits and the upper three divisor bits in its lower three bits. The divisor write carries the low eight divisor bits. Every write restarts both counting stages at once.

The transmitter and receiver each have their own source select. Each one takes either the internal enables or edges of an external clock input. The external input is first passed through a two-flop synchroniser. All inputs are synchronous to `clk`, except `ext_clk_in`.

Top module: `baud_clkgen`

## Requirements
- R1: While `rst_n` is low, and afterwards until a non-zero select code is written, `tx_tick`, `rx_tick` and `ser_clk_out` stay low.
- R2: While the select code is 0, no internal tick is produced and `ser_clk_out` is held low, including after a running configuration is stopped.
- R3: Select code c gives prescaler factor P = (c+1)/2 in reference pulses. For a half-integer P, successive prescaler intervals alternate between floor(P) and ceil(P), and the floor interval comes first after a write. For an integer P, every interval equals P.
- R4: The divisor value N-1 is 11 bits wide. Bits 10:8 come from bits 2:0 of the prescaler write, and the select code comes from bits 7:3. Bits 7:0 come from the divisor write. The internal sample tick repeats every N prescaler intervals: with P = 1 and N-1 = 5, that is every 6 reference pulses.
- R5: In asynchronous mode, with internal sources, `tx_tick` and `rx_tick` both pulse on every sample tick. `ser_clk_out` is high from the 8th through the 15th tick after a restart and low for the rest of each 16-tick cycle.
- R6: In synchronous mode, `ser_clk_out` toggles on every sample tick, and the first toggle after a restart is a rise. An internal `tx_tick` marks each rise and an internal `rx_tick` marks each fall, so the two never pulse together.
- R7: With a direction set to the external source, a rising edge on `ext_clk_in` gives a single one-cycle tick that appears 3 clock edges after the input changes. A receiver in synchronous mode uses the falling edge instead, and the other edge gives no receiver tick.
- R8: A write to either register restarts both stages and clears the final divide, so `ser_clk_out` reads low after the write. The first internal tick then follows after exactly the full programmed interval.
- R9: The transmitter and receiver source selects are independent. A transmitter on the external source stays silent without external edges while the receiver keeps its internal period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference enable at twice the base frequency |
| psr_wr | input | 1 | Write strobe: select code and divisor upper bits |
| baud_wr | input | 1 | Write strobe: divisor low byte |
| wr_data | input | 8 | Write data for either strobe |
| sync_mode | input | 1 | 0 asynchronous (final divide 16), 1 synchronous (final divide 2) |
| tx_ext_sel | input | 1 | Transmitter source: 0 internal, 1 external |
| rx_ext_sel | input | 1 | Receiver source: 0 internal, 1 external |
| ext_clk_in | input | 1 | External clock input, asynchronous |
| tx_tick | output | 1 | One-cycle transmitter clock enable |
| rx_tick | output | 1 | One-cycle receiver clock enable |
| ser_clk_out | output | 1 | Internal bit-rate square clock for pin drive |

## Verification
The bench builds the block with its default parameters: a 5-bit select, an 11-bit divisor, a final divide of 16 and a two-stage synchroniser. With the reference enable mostly held high, every interval is a whole number of cycles, so the half-step alternation at codes 2, 4 and 30 and the full factor of 16 at code 31 can each be counted exactly. The 11-bit divisor makes it possible to test a value that uses the upper bits held in the prescaler write (N = 259) within a short run. Slowing the reference enable to every other cycle shows that the chain counts reference pulses rather than clock cycles.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int REG_W = 8;

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } clk_src_e;

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } ser_mode_e;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int PSEL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              restart,
  input  logic [PSEL_W-1:0] psel,
  output logic              pre_tick
);
  logic [PSEL_W-1:0] cnt_q, cnt_d;
  logic              phase_q, phase_d;
  logic [PSEL_W:0]   sum_lo, sum_hi;
  logic [PSEL_W-1:0] span_lo, span_hi, span_m1;
  logic              active, at_end;

  // interval of floor(P) on phase 0, ceil(P) on phase 1, P = (psel+1)/2
  always_comb begin
    sum_lo  = {1'b0, psel} + (PSEL_W+1)'(1);
    sum_hi  = {1'b0, psel} + (PSEL_W+1)'(2);
    span_lo = sum_lo[PSEL_W:1];
    span_hi = sum_hi[PSEL_W:1];
    span_m1 = (phase_q ? span_hi : span_lo) - PSEL_W'(1);
    active  = (psel != '0) && !restart;
    at_end  = (cnt_q == span_m1);
    pre_tick = active && ref_en && at_end;
  end

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!active) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (ref_en) begin
      if (at_end) begin
        cnt_d   = '0;
        phase_d = ~phase_q;
      end else begin
        cnt_d = cnt_q + PSEL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assert_count_within_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel != '0) |-> (cnt_q <= span_hi - PSEL_W'(1)));

  assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel == '0) |=> (cnt_q == '0 && !phase_q));
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 11,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic             restart,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] div_n1,
  input  logic             sync_mode,
  output logic             cnt_tick,
  output logic             rise_tick,
  output logic             fall_tick,
  output logic             ser_clk
);
  localparam int FIN_W = $clog2(OVS);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [FIN_W-1:0] fin_q, fin_d;

  always_comb begin
    cnt_tick  = pre_tick && (cnt_q == '0);
    rise_tick = cnt_tick && !fin_q[0];
    fall_tick = cnt_tick && fin_q[0];
    ser_clk   = sync_mode ? fin_q[0] : fin_q[FIN_W-1];
  end

  always_comb begin
    cnt_d = cnt_q;
    fin_d = fin_q;
    if (restart) begin
      cnt_d = load_val;
      fin_d = '0;
    end else if (pre_tick) begin
      cnt_d = (cnt_q == '0) ? div_n1 : cnt_q - DIV_W'(1);
      if (cnt_tick) fin_d = fin_q + FIN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fin_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      fin_q <= fin_d;
    end
  end

  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_n1);

  assert_final_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick && !restart) |=> $stable(fin_q));
endmodule

// File: rtl/baud_ext_sync.sv
module baud_ext_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic ext_rise,
  output logic ext_fall
);
  logic [SYNC_STAGES:0] pipe_q, pipe_d;

  always_comb begin
    pipe_d   = {pipe_q[SYNC_STAGES-1:0], ext_in};
    ext_rise = pipe_q[SYNC_STAGES-1] && !pipe_q[SYNC_STAGES];
    ext_fall = !pipe_q[SYNC_STAGES-1] && pipe_q[SYNC_STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assert_single_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
  import baud_pkg::*;
#(
  parameter int PSEL_W      = 5,
  parameter int DIV_W       = 11,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic             psr_wr,
  input  logic             baud_wr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             sync_mode,
  input  logic             tx_ext_sel,
  input  logic             rx_ext_sel,
  input  logic             ext_clk_in,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             ser_clk_out
);
  localparam int HI_W = DIV_W - REG_W;

  logic [PSEL_W-1:0] psel_q, psel_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              restart, pre_tick;
  logic              cnt_tick, rise_tick, fall_tick, ser_clk;
  logic              ext_rise, ext_fall;
  logic              int_tx, int_rx, ext_tx, ext_rx;
  logic              tx_d, rx_d;
  clk_src_e          tx_src, rx_src;
  ser_mode_e         mode;

  always_comb begin
    psel_d = psel_q;
    div_d  = div_q;
    if (psr_wr) begin
      psel_d              = wr_data[REG_W-1 -: PSEL_W];
      div_d[DIV_W-1:REG_W] = wr_data[HI_W-1:0];
    end
    if (baud_wr) div_d[REG_W-1:0] = wr_data;
    restart = psr_wr || baud_wr || (psel_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel_q <= '0;
      div_q  <= '0;
    end else begin
      psel_q <= psel_d;
      div_q  <= div_d;
    end
  end

  baud_prescaler #(.PSEL_W(PSEL_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .restart(restart),
    .psel(psel_q), .pre_tick(pre_tick)
  );

  baud_divider #(.DIV_W(DIV_W), .OVS(OVS)) i_div (
    .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .restart(restart),
    .load_val(div_d), .div_n1(div_q), .sync_mode(sync_mode),
    .cnt_tick(cnt_tick), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .ser_clk(ser_clk)
  );

  baud_ext_sync #(.SYNC_STAGES(SYNC_STAGES)) i_ext (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_clk_in),
    .ext_rise(ext_rise), .ext_fall(ext_fall)
  );

  always_comb begin
    mode   = ser_mode_e'(sync_mode);
    tx_src = clk_src_e'(tx_ext_sel);
    rx_src = clk_src_e'(rx_ext_sel);
    int_tx = (mode == MODE_SYNC) ? rise_tick : cnt_tick;
    int_rx = (mode == MODE_SYNC) ? fall_tick : cnt_tick;
    ext_tx = ext_rise;
    ext_rx = (mode == MODE_SYNC) ? ext_fall : ext_rise;
    tx_d   = (tx_src == SRC_EXTERNAL) ? ext_tx : int_tx;
    rx_d   = (rx_src == SRC_EXTERNAL) ? ext_rx : int_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
    end else begin
      tx_tick <= tx_d;
      rx_tick <= rx_d;
    end
  end

  assign ser_clk_out = ser_clk;

  assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_q == '0 && !tx_ext_sel && !psr_wr) |=> !tx_tick);

  assert_sync_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !tx_ext_sel && !rx_ext_sel) |=> !(tx_tick && rx_tick));

  assert_write_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((psr_wr || baud_wr) && !tx_ext_sel) |=> !tx_tick);
endmodule

// File: tb/test_baud_clkgen.sv
`timescale 1ns/1ps
module test_baud_clkgen;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, ref_en, ref_half, psr_wr, baud_wr;
  logic [7:0] wr_data;
  logic       sync_mode, tx_ext_sel, rx_ext_sel, ext_clk_in;
  logic       tx_tick, rx_tick, ser_clk_out;
  int checks = 0;
  int errors = 0;

  baud_clkgen i_baud_clkgen (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .psr_wr(psr_wr),
    .baud_wr(baud_wr), .wr_data(wr_data), .sync_mode(sync_mode),
    .tx_ext_sel(tx_ext_sel), .rx_ext_sel(rx_ext_sel), .ext_clk_in(ext_clk_in),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .ser_clk_out(ser_clk_out)
  );

  always @(negedge clk) ref_en <= ref_half ? ~ref_en : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int span_sum(input int c, input int n, inout bit ph);
    int f = (c + 1) / 2;
    int g = (c + 2) / 2;
    int s = 0;
    for (int i = 0; i < n; i++) begin
      s += ph ? g : f;
      ph = ~ph;
    end
    return s;
  endfunction

  task automatic program_rate(input int c, input int n1);
    @(negedge clk);
    psr_wr  = 1'b1;
    wr_data = 8'(((c & 31) << 3) | ((n1 >> 8) & 7));
    @(negedge clk);
    psr_wr  = 1'b0;
    baud_wr = 1'b1;
    wr_data = 8'(n1 & 255);
    @(negedge clk);
    baud_wr = 1'b0;
  endtask

  // which: 0 tx, 1 rx, 2 either
  task automatic wait_tick(input int which, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!((which == 0 && tx_tick) || (which == 1 && rx_tick) ||
                 (which == 2 && (tx_tick || rx_tick))) && n < 4000);
  endtask

  task automatic t_reset;
    int hits = 0;
    check(!tx_tick && !rx_tick && !ser_clk_out, "R1 outputs in reset",
          {tx_tick, rx_tick, ser_clk_out}, 0);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_tick || rx_tick || ser_clk_out) hits++;
    end
    check(hits == 0, "R1 idle after reset", hits, 0);
  endtask

  task automatic t_divisor;
    int n;
    program_rate(1, 5);
    wait_tick(0, n); check(n == 6, "R4 first interval N-1=5", n, 6);
    wait_tick(0, n); check(n == 6, "R4 period N-1=5", n, 6);
    program_rate(1, 'h102);
    wait_tick(0, n); check(n == 259, "R4 upper divisor bits", n, 259);
    ref_half = 1'b1;
    program_rate(1, 2);
    wait_tick(0, n);
    wait_tick(0, n); check(n == 6, "R4 counts reference pulses", n, 6);
    ref_half = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_half_step;
    int n, e;
    bit ph;
    program_rate(4, 2);
    ph = 1'b0;
    e = span_sum(4, 3, ph); wait_tick(0, n); check(n == e, "R3 P=2.5 first", n, e);
    e = span_sum(4, 3, ph); wait_tick(0, n); check(n == e, "R3 P=2.5 second", n, e);
    program_rate(2, 0);
    ph = 1'b0;
    for (int i = 0; i < 4; i++) begin
      e = span_sum(2, 1, ph); wait_tick(0, n); check(n == e, "R3 P=1.5 alternation", n, e);
    end
    program_rate(31, 0);
    wait_tick(0, n); check(n == 16, "R3 P=16 first", n, 16);
    wait_tick(0, n); check(n == 16, "R3 P=16 period", n, 16);
    program_rate(30, 0);
    ph = 1'b0;
    e = span_sum(30, 1, ph); wait_tick(0, n); check(n == e, "R3 P=15.5 floor", n, e);
    e = span_sum(30, 1, ph); wait_tick(0, n); check(n == e, "R3 P=15.5 ceil", n, e);
  endtask

  task automatic t_async_clock;
    int n, bad = 0, rx_bad = 0;
    program_rate(1, 1);
    for (int k = 1; k <= 16; k++) begin
      wait_tick(0, n);
      if (n != 2) bad++;
      if (!rx_tick) rx_bad++;
      if (ser_clk_out != ((k % 16) >= 8)) bad++;
    end
    check(bad == 0, "R5 ser_clk_out divide by 16", bad, 0);
    check(rx_bad == 0, "R5 rx_tick with tx_tick", rx_bad, 0);
  endtask

  task automatic t_sync_clock;
    int n, bad = 0;
    sync_mode = 1'b1;
    program_rate(1, 2);
    for (int k = 0; k < 4; k++) begin
      wait_tick(2, n);
      if (n != 3) bad++;
      if (tx_tick == rx_tick) bad++;
      if (tx_tick != (k % 2 == 0)) bad++;
      if (ser_clk_out != tx_tick) bad++;
    end
    check(bad == 0, "R6 sync rise/fall ticks", bad, 0);
    sync_mode = 1'b0;
  endtask

  task automatic t_stop;
    int hits = 0;
    program_rate(1, 2);
    repeat (20) @(negedge clk);
    program_rate(0, 0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tx_tick || rx_tick || ser_clk_out) hits++;
    end
    check(hits == 0, "R2 stopped chain", hits, 0);
  endtask

  task automatic t_ext_tx;
    int pos = 0, cnt = 0, rxc = 0;
    program_rate(0, 0);
    tx_ext_sel = 1'b1;
    @(negedge clk) ext_clk_in = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (tx_tick) begin cnt++; pos = i; end
      if (rx_tick) rxc++;
    end
    check(cnt == 1 && pos == 3, "R7 external rise latency", pos, 3);
    check(rxc == 0, "R9 rx unaffected by tx external", rxc, 0);
    ext_clk_in = 1'b0;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tx_tick) cnt++;
    end
    check(cnt == 0, "R7 falling edge ignored by tx", cnt, 0);
    tx_ext_sel = 1'b0;
  endtask

  task automatic t_ext_rx_sync;
    int pos = 0, cnt = 0;
    sync_mode = 1'b1;
    rx_ext_sel = 1'b1;
    @(negedge clk) ext_clk_in = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (rx_tick) cnt++;
    end
    check(cnt == 0, "R7 sync rx ignores rise", cnt, 0);
    ext_clk_in = 1'b0;
    cnt = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (rx_tick) begin cnt++; pos = i; end
    end
    check(cnt == 1 && pos == 3, "R7 sync rx on fall", pos, 3);
    rx_ext_sel = 1'b0;
    sync_mode  = 1'b0;
  endtask

  task automatic t_independent;
    int txc = 0, rxc = 0;
    tx_ext_sel = 1'b1;
    program_rate(1, 3);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (tx_tick) txc++;
      if (rx_tick) rxc++;
    end
    check(rxc == 3, "R9 rx internal period", rxc, 3);
    check(txc == 0, "R9 tx external silent", txc, 0);
    tx_ext_sel = 1'b0;
  endtask

  task automatic t_reload;
    int n;
    program_rate(1, 0);
    repeat (10) @(negedge clk);
    check(ser_clk_out == 1'b1, "R8 ser high before write", ser_clk_out, 1);
    program_rate(1, 9);
    check(ser_clk_out == 1'b0, "R8 ser cleared by write", ser_clk_out, 0);
    wait_tick(0, n);
    repeat (4) @(negedge clk);
    program_rate(1, 9);
    wait_tick(0, n); check(n == 10, "R8 full interval after rewrite", n, 10);
  endtask

  initial begin
    rst_n = 1'b0; ref_half = 1'b0; psr_wr = 1'b0; baud_wr = 1'b0; wr_data = '0;
    sync_mode = 1'b0; tx_ext_sel = 1'b0; rx_ext_sel = 1'b0; ext_clk_in = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_divisor();
    t_half_step();
    t_async_clock();
    t_sync_clock();
    t_stop();
    t_ext_tx();
    t_ext_rx_sync();
    t_independent();
    t_reload();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule